// File: doc/BRIEF.md
# Eight-Channel Down-Counter Timer Bank

This block is a bank of eight byte-programmed down-counters placed behind an 8-bit write port on a 16-bit host I/O space. Each channel is reached at its own address in an aligned window of eight. The three lowest channels are timers. They divide the system clock by 16 and then by their time constant, and drive a memory refresh tick and the transmit/receive clocks of two serial ports. The five upper channels are event counters. They count rising edges on their own trigger input, and one of them serves as the system tick.

Software programs a channel in two writes. The first is a control byte that can stop the channel, set its interrupt enable and announce a time constant. The second is the constant itself, which starts the count. At terminal count each channel reloads by itself and pulses its output for one clock. An upper channel with its interrupt enabled also latches a pending request. Pending requests are resolved by fixed priority into a single request line and an 8-bit vector. An external acknowledge controller clears the winning request with a one-cycle strobe.

Top module: `ctc_bank8`

## Requirements
- R1: A write is accepted only when io_addr[15:3] equals bits 15:3 of BASE_ADDR (default 0x0210). It then goes to channel io_addr[2:0]. Writes to any other address change no channel state and no output.
- R2: A byte with bit 0 = 1 written to a channel that is not waiting for a constant is a control byte. In it, bit 7 is the interrupt enable, bit 2 = 1 makes the next write to that channel its time constant, and bit 1 = 1 stops the channel until a constant is written. A byte with bit 0 = 0 written to such a channel sets the vector base to data bits 7:4.
- R3: Writing a time constant loads it as the count at once, restarts the channel's prescaler and starts the channel, even if the channel was already running.
- R4: Channels 0 to 2 step once every 16 clocks. A constant N gives a zero-count pulse every 16·N clocks, so the constants 1, 2, 4, 8, 16, 32, 64 and 87 give serial rates in the ratio 9600, 4800, 2400, 1200, 600, 300, 150 and about 110 (87 gives 1392 clocks).
- R5: Channels 3 to 7 step on each clock where their trigger input ext_trg[ch-3] is 1 after a 0 on the previous clock. No prescaler is applied.
- R6: A time constant of 0 counts as 256 steps.
- R7: On the step that ends a count, the channel reloads its constant and raises its zc_out bit for exactly one clock, starting on the next clock.
- R8: Channels 0 to 2 never raise an interrupt request, whatever their enable bit.
- R9: A zero-count pulse of channel 3 to 7 with its enable set latches a pending request in the same cycle. The request stays until cleared, and irq is 1 exactly when any request is pending.
- R10: The lowest-numbered pending channel wins. irq_vec = {base[3:0], winner[2:0], 1'b0}. An int_clr strobe clears only the winner's request. A request raised in the same cycle as its clear stays pending.
- R11: After reset every channel is stopped, no constant is awaited, enables and vector base are 0, and zc_out, irq and irq_vec are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Write data byte |
| ext_trg | input | 5 | Trigger inputs of channels 3 to 7 (bit 0 = channel 3) |
| int_clr | input | 1 | Clears the pending request of the current winner |
| zc_out | output | 8 | Zero-count pulses, one bit per channel |
| irq | output | 1 | Some request is pending |
| irq_vec | output | 8 | Vector of the winning channel |

## Verification
The timer channels run with constants 2, 87 and 0 side by side. The 87 case measures the slowest serial period exactly, and the 0 case separates a count of 256 from a count of 0. Counter channels receive single and simultaneous trigger pulses. Simultaneous pulses on channels 3 and 5 separate lowest-index priority from highest-index priority and check that one clear strobe drops only one request. Stray writes just outside the address window, a halt byte followed by pulses, and reloading a running channel show whether decode, stop and immediate reload act as stated. A cycle-by-cycle model compares every output on every clock.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int BYTE_W   = 8;
  localparam int CH_N     = 8;
  localparam int CH_IDX_W = $clog2(CH_N);

  // control byte bit positions
  localparam int CW_CTL  = 0;
  localparam int CW_HALT = 1;
  localparam int CW_TCF  = 2;
  localparam int CW_IE   = 7;

  // next count after one step; 1 is the last step, reload follows
  function automatic logic [BYTE_W-1:0] count_step(input logic [BYTE_W-1:0] cur,
                                                   input logic [BYTE_W-1:0] tc);
    return (cur == BYTE_W'(1)) ? tc : cur - BYTE_W'(1);
  endfunction

  function automatic logic port_hit(input logic [15:0] addr, input logic [15:0] base);
    return addr[15:CH_IDX_W] == base[15:CH_IDX_W];
  endfunction

  function automatic logic [BYTE_W-1:0] make_vector(input logic [3:0] hi,
                                                    input logic [CH_IDX_W-1:0] idx);
    return {hi, idx, 1'b0};
  endfunction
endpackage

// File: rtl/ctc_prio.sv
module ctc_prio #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any   = |req;
  assign grant = any ? (N'(1) << idx) : '0;
endmodule

// File: rtl/ctc_chan.sv
module ctc_chan
  import ctc_pkg::*;
#(
  parameter int IS_TIMER = 1,
  parameter int IRQ_CAP  = 0,
  parameter int PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ext_i,
  input  logic              clr_i,
  output logic              await_o,
  output logic              zc_o,
  output logic              pend_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic              run_q, await_q, ie_q, ext_q, zc_q, pend_q;
  logic [BYTE_W-1:0] cnt_q, tc_q;

  // named internal events
  logic wr_tc, wr_ctl, stop_req, pre_tick, ext_rise, step_evt, zero_evt, ie_eff;

  assign wr_tc    = sel & await_q;
  assign wr_ctl   = sel & ~await_q & wdata[CW_CTL];
  assign stop_req = wr_ctl & wdata[CW_HALT];
  assign ext_rise = ext_i & ~ext_q;

  generate
    if (IS_TIMER != 0) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (wr_tc)   pre_q <= '0;
        else if (run_q)   pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
      end
      assign pre_tick = run_q & (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign pre_tick = 1'b0;
    end
  endgenerate

  assign step_evt = run_q & ~wr_tc & ~stop_req & ((IS_TIMER != 0) ? pre_tick : ext_rise);
  assign zero_evt = step_evt & (cnt_q == BYTE_W'(1));
  assign ie_eff   = (IRQ_CAP != 0) & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      await_q <= 1'b0;
      ie_q    <= 1'b0;
      ext_q   <= 1'b0;
      zc_q    <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      tc_q    <= '0;
    end else begin
      ext_q  <= ext_i;
      zc_q   <= zero_evt;
      pend_q <= (pend_q & ~clr_i) | (zero_evt & ie_eff);
      if (wr_tc) begin
        tc_q    <= wdata;
        cnt_q   <= wdata;
        run_q   <= 1'b1;
        await_q <= 1'b0;
      end else begin
        if (wr_ctl) begin
          ie_q    <= wdata[CW_IE];
          await_q <= wdata[CW_TCF];
          if (wdata[CW_HALT]) run_q <= 1'b0;
        end
        if (step_evt) cnt_q <= count_step(cnt_q, tc_q);
      end
    end
  end

  assign await_o = await_q;
  assign zc_o    = zc_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/ctc_bank8.sv
module ctc_bank8
  import ctc_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0210,
  parameter int          NUM_TIMER = 3,
  parameter int          PRESCALE  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      io_wr,
  input  logic [15:0]               io_addr,
  input  logic [BYTE_W-1:0]         io_wdata,
  input  logic [CH_N-NUM_TIMER-1:0] ext_trg,
  input  logic                      int_clr,
  output logic [CH_N-1:0]           zc_out,
  output logic                      irq,
  output logic [BYTE_W-1:0]         irq_vec
);
  logic                hit;
  logic [CH_IDX_W-1:0] ch_sel, win_idx;
  logic [CH_N-1:0]     sel_w, await_w, pend_w, win_1h, clr_w;
  logic [3:0]          base_q;
  logic                vec_wr;

  assign hit    = io_wr & port_hit(io_addr, BASE_ADDR);
  assign ch_sel = io_addr[CH_IDX_W-1:0];
  assign sel_w  = hit ? (CH_N'(1) << ch_sel) : '0;
  assign vec_wr = hit & ~await_w[ch_sel] & ~io_wdata[CW_CTL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (vec_wr) base_q <= io_wdata[BYTE_W-1:BYTE_W-4];
  end

  generate
    for (genvar g = 0; g < CH_N; g++) begin : g_ch
      if (g < NUM_TIMER) begin : g_tmr
        ctc_chan #(.IS_TIMER(1), .IRQ_CAP(0), .PRESCALE(PRESCALE)) u_ch (
          .clk(clk), .rst_n(rst_n), .sel(sel_w[g]), .wdata(io_wdata),
          .ext_i(1'b0), .clr_i(clr_w[g]), .await_o(await_w[g]),
          .zc_o(zc_out[g]), .pend_o(pend_w[g]));
      end else begin : g_cnt
        ctc_chan #(.IS_TIMER(0), .IRQ_CAP(1), .PRESCALE(PRESCALE)) u_ch (
          .clk(clk), .rst_n(rst_n), .sel(sel_w[g]), .wdata(io_wdata),
          .ext_i(ext_trg[g-NUM_TIMER]), .clr_i(clr_w[g]), .await_o(await_w[g]),
          .zc_o(zc_out[g]), .pend_o(pend_w[g]));
      end
    end
  endgenerate

  ctc_prio #(.N(CH_N)) u_prio (
    .req(pend_w), .any(irq), .idx(win_idx), .grant(win_1h));

  assign clr_w   = int_clr ? win_1h : '0;
  assign irq_vec = make_vector(base_q, win_idx);
endmodule

// File: rtl/ctc_bank8_chk.sv
module ctc_bank8_chk #(
  parameter int N         = 8,
  parameter int NUM_TIMER = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         int_clr,
  input logic [N-1:0] zc_out,
  input logic         irq,
  input logic [7:0]   irq_vec,
  input logic [N-1:0] pend
);
  logic [2:0]   win;
  logic [N-1:0] low_mask;
  assign win      = irq_vec[3:1];
  assign low_mask = (N'(1) << win) - N'(1);

  // R7
  zc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_out != '0) |=> ((zc_out & $past(zc_out)) == '0));

  // R8
  timer_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[NUM_TIMER-1:0] == '0);

  // R9
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|pend));

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_clr |=> (($past(pend) & ~pend) == '0));

  // R9
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~zc_out) == '0));

  // R10
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[win] && ((pend & low_mask) == '0)));

  // R10
  clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && irq) |=> ($countones($past(pend) & ~pend) <= 1));
endmodule

bind ctc_bank8 ctc_bank8_chk #(.N(8), .NUM_TIMER(NUM_TIMER)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_clr(int_clr), .zc_out(zc_out),
  .irq(irq), .irq_vec(irq_vec), .pend(pend_w));

// File: tb/tb_ctc_bank8.sv
`timescale 1ns/1ps
module tb_ctc_bank8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [4:0]  ext_trg = '0;
  logic        int_clr = 1'b0;
  logic [7:0]  zc_out;
  logic        irq;
  logic [7:0]  irq_vec;

  always #2 clk = ~clk;  // 250 MHz

  ctc_bank8 dut (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .ext_trg(ext_trg), .int_clr(int_clr),
    .zc_out(zc_out), .irq(irq), .irq_vec(irq_vec));

  int checks = 0, failures = 0, cyc = 0;
  string phase = "R11";

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_rem[8], m_tc[8], m_pre[8];
  bit m_run[8], m_aw[8], m_ie[8], m_pend[8], m_zc[8], m_extp[8];
  int m_base, m_win, m_win2, m_ch;
  bit m_hit, m_vec, m_load, m_ctl, m_stop, m_evt, m_extv, m_set;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin
        m_rem[c] = 0; m_tc[c] = 0; m_pre[c] = 0; m_run[c] = 0; m_aw[c] = 0;
        m_ie[c] = 0; m_pend[c] = 0; m_zc[c] = 0; m_extp[c] = 0;
      end
      m_base = 0;
    end else begin
      m_win = -1;
      for (int c = 0; c < 8; c++) if (m_pend[c] && m_win < 0) m_win = c;
      m_hit = io_wr && ((io_addr >> 3) == (16'h0210 >> 3));
      m_ch  = int'(io_addr & 16'h7);
      m_vec = m_hit && !m_aw[m_ch] && !io_wdata[0];
      for (int c = 0; c < 8; c++) begin
        m_load = m_hit && m_ch == c && m_aw[c];
        m_ctl  = m_hit && m_ch == c && !m_aw[c] && io_wdata[0];
        m_stop = m_ctl && io_wdata[1];
        m_extv = (c >= 3) ? ext_trg[c-3] : 1'b0;
        m_evt  = 0;
        m_set  = 0;
        if (m_run[c]) begin
          if (c < 3) begin
            m_evt = (m_pre[c] == 15);
            m_pre[c] = (m_pre[c] + 1) % 16;
          end else m_evt = m_extv && !m_extp[c];
        end
        m_extp[c] = m_extv;
        m_zc[c] = 0;
        if (m_evt && !m_load && !m_stop) begin
          if (m_rem[c] == 1) begin
            m_zc[c] = 1;
            m_rem[c] = (m_tc[c] == 0) ? 256 : m_tc[c];
            m_set = (c >= 3) && m_ie[c];
          end else m_rem[c] = m_rem[c] - 1;
        end
        if (int_clr && m_win == c) m_pend[c] = 0;
        if (m_set) m_pend[c] = 1;
        if (m_load) begin
          m_tc[c] = io_wdata; m_rem[c] = (io_wdata == 0) ? 256 : io_wdata;
          m_run[c] = 1; m_aw[c] = 0; m_pre[c] = 0;
        end else if (m_ctl) begin
          m_ie[c] = io_wdata[7]; m_aw[c] = io_wdata[2];
          if (io_wdata[1]) m_run[c] = 0;
        end
      end
      if (m_vec) m_base = io_wdata[7:4];
    end
  end

  // compare every clock, away from the active edge
  logic [7:0] exp_zc;
  always @(negedge clk) begin
    if (rst_n) begin
      m_win2 = -1;
      for (int c = 0; c < 8; c++) begin
        exp_zc[c] = m_zc[c];
        if (m_pend[c] && m_win2 < 0) m_win2 = c;
      end
      chk({phase, " zc_out"}, {24'b0, zc_out}, {24'b0, exp_zc});
      chk({phase, " irq"}, {31'b0, irq}, {31'b0, m_win2 >= 0});
      if (m_win2 >= 0) chk({phase, " irq_vec"}, {24'b0, irq_vec}, 32'((m_base << 4) | (m_win2 << 1)));
    end
  end

  // independent pulse counters, sampled just after each edge
  int zc_cnt[8];
  int t_prev1, gap1;
  bit irq_seen;
  always @(posedge clk) begin
    cyc++;
    #1;
    for (int c = 0; c < 8; c++) if (zc_out[c]) zc_cnt[c]++;
    if (zc_out[1]) begin
      if (t_prev1 > 0) gap1 = cyc - t_prev1;
      t_prev1 = cyc;
    end
    if (irq) irq_seen = 1;
  end

  task automatic clr_counts();
    for (int c = 0; c < 8; c++) zc_cnt[c] = 0;
    irq_seen = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [4:0] m, input int n);
    repeat (n) begin
      @(negedge clk); ext_trg = m;
      @(negedge clk); ext_trg = '0;
    end
    idle(2);
  endtask

  task automatic clear_int();
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0;
    idle(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<200000", cyc);
    finish_run();
  end

  initial begin
    idle(5);
    chk("R11 zc after reset", {24'b0, zc_out}, 32'h0);
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);
    chk("R11 vec after reset", {24'b0, irq_vec}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(40);
    chk("R11 no pulse unprogrammed", {24'b0, zc_out}, 32'h0);

    phase = "R4";
    wr(16'h0210, 8'h05); wr(16'h0210, 8'd2);
    wr(16'h0211, 8'h85); wr(16'h0211, 8'd87);   // R8: enable set on timer
    wr(16'h0212, 8'h05); wr(16'h0212, 8'd0);    // R6: timer count 256
    clr_counts();
    idle(3000);
    chk("R4 ch1 period for constant 87", gap1, 16 * 87);
    chk("R8 timer channels raise no irq", {31'b0, irq_seen}, 32'h0);

    phase = "R1";
    wr(16'h0218, 8'h07); wr(16'h020F, 8'h07); wr(16'h1210, 8'h07);
    clr_counts();
    idle(320);
    chk("R1 ch0 unaffected by stray writes", zc_cnt[0], 10);

    phase = "R5";
    wr(16'h0210, 8'h40);                         // R2 vector base
    wr(16'h0213, 8'h85); wr(16'h0213, 8'd3);
    clr_counts();
    pulse(5'b00001, 6);
    chk("R5 ch3 pulses for 6 edges", zc_cnt[3], 2);
    chk("R9 irq pending", {31'b0, irq}, 32'h1);
    chk("R10 vector ch3", {24'b0, irq_vec}, 32'h46);

    phase = "R10";
    wr(16'h0215, 8'h85); wr(16'h0215, 8'd1);
    clear_int();
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    pulse(5'b00101, 3);
    chk("R10 lowest wins", {24'b0, irq_vec}, 32'h46);
    clear_int();
    chk("R10 one clear leaves ch5", {24'b0, irq_vec}, 32'h4A);
    chk("R10 irq still high", {31'b0, irq}, 32'h1);
    clear_int();
    chk("R9 all cleared", {31'b0, irq}, 32'h0);

    phase = "R6";
    wr(16'h0214, 8'h05); wr(16'h0214, 8'd0);
    clr_counts();
    pulse(5'b00010, 255);
    chk("R6 no pulse after 255 edges", zc_cnt[4], 0);
    pulse(5'b00010, 1);
    chk("R6 pulse at edge 256", zc_cnt[4], 1);
    chk("R9 disabled channel no irq", {31'b0, irq_seen}, 32'h0);

    phase = "R2";
    wr(16'h0213, 8'h03);
    clr_counts();
    pulse(5'b00001, 5);
    chk("R2 halted ch3 does not count", zc_cnt[3], 0);
    wr(16'h0213, 8'h05); wr(16'h0213, 8'd2);
    clr_counts();
    pulse(5'b00001, 4);
    chk("R3 restart with constant 2", zc_cnt[3], 2);
    chk("R7 one clock per terminal count", zc_cnt[3] + zc_cnt[5], 2);

    phase = "R3";
    wr(16'h0210, 8'h05); wr(16'h0210, 8'd8);
    idle(2);
    clr_counts();
    idle(1280);
    chk("R3 reload of running ch0", zc_cnt[0], 10);

    idle(10);
    finish_run();
  end
endmodule